// File: doc/BRIEF.md
# Folded Key Equation Solver for a Four-Error Reed-Solomon Decoder

This block sits between syndrome computation and the root search of a hard-decision Reed-Solomon decoder that corrects up to four symbol errors over GF(2^10). It accepts the eight syndromes on a single bus with a start strobe. It runs an inversion-free Berlekamp-Massey iteration that solves (1+S(x))·Λ(x) = Ω(x) mod x^9. It then presents the error locator Λ and the evaluator Ω with a one-cycle done strobe. The evaluator comes straight out of the iteration, with no separate product step.

The datapath is folded. Two rings of thirteen coefficient registers, a working ring and an auxiliary ring, rotate past one shared processing element that updates one coefficient per clock. The working ring holds the full product (1+S)·Λ up to x^8, plus the four upper coefficients of Λ. Because the product is held directly, each discrepancy is simply one ring entry and needs no inner product. Eight iterations of thirteen cycles give a fixed latency of 104 clocks. The degree of the final locator is reported so that the downstream logic can compare it with the number of roots found.

Top module: `rs_keyeq_solver`

## Requirements
- R1: After reset, done_o is 0 and lambda_o, omega_o and lambda_deg_o are all zero.
- R2: A start_i sampled high at a rising edge while idle is accepted. done_o is then high for exactly one cycle, following the 104th rising edge after the accepting edge.
- R3: Field and bus layout: the field is GF(2^10) with primitive polynomial x^10+x^3+1 in polynomial basis, α = 2. Syndrome S_j sits at synd_i[10(j-1)+:10] for j = 1..8. Coefficient Λ_k sits at lambda_o[10k+:10]. If S_j = Σ Y_i·X_i^j for ν ≤ 4 distinct nonzero locators X_i and nonzero magnitudes Y_i, then Λ_0 ≠ 0 and Λ_k = Λ_0·L_k for k = 0..4, where L(x) = Π(1 + X_i·x).
- R4: For any syndromes, omega_o[10k+:10] equals coefficient k of (1+S(x))·Λ(x), for k = 0..4. Here S(x) = Σ S_j·x^j and Λ is the presented locator.
- R5: lambda_deg_o equals the largest k in 1..4 with Λ_k ≠ 0, or 0 if there is none. For a correctable pattern this is ν.
- R6: All-zero syndromes give exactly Λ(x) = 1 and Ω(x) = 1.
- R7: A start_i received while a solve is in progress is ignored. The running solve keeps its timing and its result is that of the accepted syndromes.
- R8: lambda_o, omega_o and lambda_deg_o hold their values until the next accepted start, whatever synd_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe; loads synd_i when idle |
| synd_i | input | 80 | Eight 10-bit syndromes, S_1 in the low bits |
| done_o | output | 1 | One-cycle pulse when results are valid |
| lambda_o | output | 50 | Error locator coefficients Λ_0..Λ_4, Λ_0 in the low bits |
| omega_o | output | 50 | Evaluator coefficients Ω_0..Ω_4, Ω_0 in the low bits |
| lambda_deg_o | output | 3 | Degree of the presented locator |

## Verification
The empty pattern is tested. A solver that lets an iteration with zero discrepancy rescale or shift the locator would return something other than exactly 1 there. Patterns of four errors fill every locator slot, so a wrong fold between the product part and the locator part of the ring, or a shift-in taken from the wrong slot, shows up as a locator that no longer factors into the error positions. A start pulse in the middle of a run catches a controller that restarts or reloads, which would move the done pulse or change the result. Random syndrome words beyond the correction limit check that the evaluator stays the truncated product and that the reported degree tracks the presented coefficients.

// File: rtl/ks_pkg.sv
package ks_pkg;

  // Default geometry: 10-bit symbols, four correctable errors.
  parameter int DEF_SYM_W = 10;
  parameter int DEF_T     = 4;
  // Low bits of x^10 + x^3 + 1.
  parameter logic [DEF_SYM_W-1:0] DEF_PRIM = 10'b00_0000_1001;

  // Source of the shifted auxiliary coefficient fed to the processing element.
  typedef enum logic [1:0] {
    SHIN_ZERO = 2'd0,   // constant coefficient of x*B is zero
    SHIN_HELD = 2'd1,   // first locator slot takes the held constant term
    SHIN_PREV = 2'd2    // otherwise the coefficient one slot earlier
  } shin_sel_e;

endpackage

// File: rtl/ks_gf_mul.sv
module ks_gf_mul #(
  parameter int            W    = 10,
  parameter logic [W-1:0]  PRIM = 10'b00_0000_1001
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);

  // Horner evaluation over the bits of b, reducing after every doubling.
  always_comb begin
    logic [W-1:0] acc;
    acc = '0;
    for (int i = W-1; i >= 0; i--) begin
      acc = {acc[W-2:0], 1'b0} ^ (acc[W-1] ? PRIM : '0);
      if (b_i[i]) acc = acc ^ a_i;
    end
    p_o = acc;
  end

endmodule

// File: rtl/ks_ring.sv
module ks_ring #(
  parameter int W = 10,
  parameter int N = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [N-1:0][W-1:0] load_vec_i,
  input  logic                shift_i,
  input  logic [W-1:0]        tail_i,
  output logic [W-1:0]        head_o,
  output logic [N-1:0][W-1:0] cells_o
);

  logic [N-1:0][W-1:0] cell_q, cell_d;
  logic                cell_en;

  assign cell_en = load_i | shift_i;

  // Next-state: parallel load has priority; shifting moves every entry one
  // place toward the head and appends the processed coefficient at the tail.
  always_comb begin
    cell_d = cell_q;
    if (load_i) begin
      cell_d = load_vec_i;
    end else if (shift_i) begin
      for (int i = 0; i < N-1; i++) cell_d[i] = cell_q[i+1];
      cell_d[N-1] = tail_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cell_q <= '0;
    else if (cell_en) cell_q <= cell_d;
  end

  assign head_o  = cell_q[0];
  assign cells_o = cell_q;

endmodule

// File: rtl/ks_pe.sv
module ks_pe
  import ks_pkg::*;
#(
  parameter int           W    = 10,
  parameter logic [W-1:0] PRIM = 10'b00_0000_1001,
  parameter int           SLW  = 4,
  parameter int           LOC1 = 9      // slot holding the x^1 locator coefficient
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [SLW-1:0] slot_i,
  input  logic [W-1:0]   main_i,
  input  logic [W-1:0]   aux_i,
  input  logic [W-1:0]   gamma_i,
  input  logic [W-1:0]   delta_i,
  input  logic           swap_i,
  output logic [W-1:0]   main_o,
  output logic [W-1:0]   aux_o
);

  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] cst_q, cst_d;
  logic [W-1:0] shin;
  logic [W-1:0] g_term, d_term;
  shin_sel_e    sel;

  always_comb begin
    if (slot_i == '0)                sel = SHIN_ZERO;
    else if (slot_i == SLW'(LOC1))   sel = SHIN_HELD;
    else                             sel = SHIN_PREV;
  end

  always_comb begin
    case (sel)
      SHIN_ZERO: shin = '0;
      SHIN_HELD: shin = cst_q;
      default:   shin = prev_q;
    endcase
  end

  ks_gf_mul #(.W(W), .PRIM(PRIM)) u_mul_gamma (
    .a_i (main_i),
    .b_i (gamma_i),
    .p_o (g_term)
  );

  ks_gf_mul #(.W(W), .PRIM(PRIM)) u_mul_delta (
    .a_i (shin),
    .b_i (delta_i),
    .p_o (d_term)
  );

  // Working update gamma*A - delta*x*B; auxiliary takes old A or x*B.
  assign main_o = g_term ^ d_term;
  assign aux_o  = swap_i ? main_i : shin;

  always_comb begin
    prev_d = aux_i;
    cst_d  = (slot_i == '0) ? aux_i : cst_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cst_q  <= '0;
    end else if (en_i) begin
      prev_q <= prev_d;
      cst_q  <= cst_d;
    end
  end

endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl #(
  parameter int W    = 10,
  parameter int ROW  = 13,
  parameter int ITER = 8,
  localparam int SLW = $clog2(ROW),
  localparam int ITW = $clog2(ITER),
  localparam int KW  = $clog2(2*ITER+2) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   first_synd_i,
  input  logic [W-1:0]   new_main_i,
  output logic           busy_o,
  output logic           load_o,
  output logic [SLW-1:0] slot_o,
  output logic [W-1:0]   gamma_o,
  output logic [W-1:0]   delta_o,
  output logic           swap_o,
  output logic           done_o
);

  logic                 busy_q, busy_d;
  logic [SLW-1:0]       slot_q, slot_d;
  logic [ITW-1:0]       iter_q, iter_d;
  logic [W-1:0]         gamma_q, gamma_d;
  logic [W-1:0]         delta_q, delta_d;
  logic [W-1:0]         dnext_q, dnext_d;
  logic signed [KW-1:0] klen_q, klen_d;
  logic                 done_q, done_d;
  logic                 load, swap, last_slot, last_iter, ctl_en;

  assign load      = start_i & ~busy_q;
  assign last_slot = (slot_q == SLW'(ROW-1));
  assign last_iter = (iter_q == ITW'(ITER-1));
  assign swap      = (delta_q != '0) && !klen_q[KW-1];
  assign ctl_en    = load | busy_q | done_q;

  always_comb begin
    busy_d  = busy_q;
    slot_d  = slot_q;
    iter_d  = iter_q;
    gamma_d = gamma_q;
    delta_d = delta_q;
    dnext_d = dnext_q;
    klen_d  = klen_q;
    done_d  = 1'b0;
    if (load) begin
      busy_d  = 1'b1;
      slot_d  = '0;
      iter_d  = '0;
      gamma_d = W'(1);
      delta_d = first_synd_i;
      klen_d  = '0;
    end else if (busy_q) begin
      slot_d = last_slot ? '0 : slot_q + 1'b1;
      // Look-ahead: next iteration's discrepancy leaves the PE two slots on.
      if (slot_q == SLW'(iter_q) + SLW'(2)) dnext_d = new_main_i;
      if (last_slot) begin
        gamma_d = swap ? delta_q : gamma_q;
        klen_d  = swap ? (-klen_q - KW'(1)) : (klen_q + KW'(1));
        delta_d = dnext_q;
        iter_d  = iter_q + 1'b1;
        if (last_iter) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      slot_q  <= '0;
      iter_q  <= '0;
      gamma_q <= '0;
      delta_q <= '0;
      dnext_q <= '0;
      klen_q  <= '0;
      done_q  <= 1'b0;
    end else if (ctl_en) begin
      busy_q  <= busy_d;
      slot_q  <= slot_d;
      iter_q  <= iter_d;
      gamma_q <= gamma_d;
      delta_q <= delta_d;
      dnext_q <= dnext_d;
      klen_q  <= klen_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = busy_q;
  assign load_o  = load;
  assign slot_o  = slot_q;
  assign gamma_o = gamma_q;
  assign delta_o = delta_q;
  assign swap_o  = swap;
  assign done_o  = done_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R2
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(busy_q && last_slot && last_iter));

  // R7
  busy_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_slot) |=> (busy_q && slot_q == $past(slot_q) + 1'b1));

  // R3
  gamma_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (gamma_q != '0));

  // R3
  discrepancy_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && slot_q == SLW'(iter_q) + SLW'(1)) |-> (new_main_i == '0));

endmodule

// File: rtl/rs_keyeq_solver.sv
module rs_keyeq_solver
  import ks_pkg::*;
#(
  parameter int                  SYM_W = DEF_SYM_W,
  parameter int                  T     = DEF_T,
  parameter logic [SYM_W-1:0]    PRIM  = DEF_PRIM,
  localparam int NSYN  = 2*T,
  localparam int ROW   = 3*T + 1,
  localparam int SLW   = $clog2(ROW),
  localparam int DEG_W = $clog2(T+1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [NSYN*SYM_W-1:0]     synd_i,
  output logic                      done_o,
  output logic [(T+1)*SYM_W-1:0]    lambda_o,
  output logic [(T+1)*SYM_W-1:0]    omega_o,
  output logic [DEG_W-1:0]          lambda_deg_o
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_sync_q, rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rst_n = rst_sync_q;

  logic [ROW-1:0][SYM_W-1:0] init_vec;
  logic [ROW-1:0][SYM_W-1:0] main_cells, aux_cells;
  logic [SYM_W-1:0]          main_head, aux_head, pe_main, pe_aux;
  logic [SYM_W-1:0]          gamma, delta;
  logic [SLW-1:0]            slot;
  logic                      busy, load, swap;

  // Initial row: product 1+S(x) in slots 0..2t, locator tail zero.
  assign init_vec[0] = SYM_W'(1);
  for (genvar j = 1; j < ROW; j++) begin : g_init
    if (j <= NSYN) begin : g_syn
      assign init_vec[j] = synd_i[(j-1)*SYM_W +: SYM_W];
    end else begin : g_zero
      assign init_vec[j] = '0;
    end
  end

  ks_ctrl #(.W(SYM_W), .ROW(ROW), .ITER(NSYN)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .start_i      (start_i),
    .first_synd_i (synd_i[SYM_W-1:0]),
    .new_main_i   (pe_main),
    .busy_o       (busy),
    .load_o       (load),
    .slot_o       (slot),
    .gamma_o      (gamma),
    .delta_o      (delta),
    .swap_o       (swap),
    .done_o       (done_o)
  );

  ks_ring #(.W(SYM_W), .N(ROW)) u_ring_main (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (load),
    .load_vec_i (init_vec),
    .shift_i    (busy),
    .tail_i     (pe_main),
    .head_o     (main_head),
    .cells_o    (main_cells)
  );

  ks_ring #(.W(SYM_W), .N(ROW)) u_ring_aux (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (load),
    .load_vec_i (init_vec),
    .shift_i    (busy),
    .tail_i     (pe_aux),
    .head_o     (aux_head),
    .cells_o    (aux_cells)
  );

  ks_pe #(.W(SYM_W), .PRIM(PRIM), .SLW(SLW), .LOC1(NSYN+1)) u_pe (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .en_i    (busy),
    .slot_i  (slot),
    .main_i  (main_head),
    .aux_i   (aux_head),
    .gamma_i (gamma),
    .delta_i (delta),
    .swap_i  (swap),
    .main_o  (pe_main),
    .aux_o   (pe_aux)
  );

  // Product and locator share the constant term in slot 0.
  for (genvar k = 0; k <= T; k++) begin : g_out
    assign omega_o[k*SYM_W +: SYM_W] = main_cells[k];
    if (k == 0) begin : g_l0
      assign lambda_o[k*SYM_W +: SYM_W] = main_cells[0];
    end else begin : g_lk
      assign lambda_o[k*SYM_W +: SYM_W] = main_cells[NSYN+k];
    end
  end

  always_comb begin
    lambda_deg_o = '0;
    for (int k = 1; k <= T; k++) begin
      if (main_cells[NSYN+k] != '0) lambda_deg_o = DEG_W'(k);
    end
  end

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(main_cells));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done_o));

  // R7
  aux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && start_i) |=> !$past(load));

endmodule

// File: tb/rs_keyeq_solver_bench.sv
`timescale 1ns/1ps
module rs_keyeq_solver_bench;

  localparam int W = 10;
  localparam int T = 4;
  localparam int NS = 2*T;
  localparam logic [W-1:0] PR = 10'b00_0000_1001;
  localparam int LAT = 104;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [NS*W-1:0] synd_bus;
  logic            done;
  logic [(T+1)*W-1:0] lam_bus, om_bus;
  logic [2:0]      deg;

  int checks = 0;
  int errors = 0;

  rs_keyeq_solver u_rs_keyeq_solver (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .synd_i       (synd_bus),
    .done_o       (done),
    .lambda_o     (lam_bus),
    .omega_o      (om_bus),
    .lambda_deg_o (deg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] fmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r, s;
    r = '0;
    s = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) r = r ^ s;
      s = s[W-1] ? ({s[W-2:0], 1'b0} ^ PR) : {s[W-2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [W-1:0] fpow(input logic [W-1:0] a, input int e);
    logic [W-1:0] r;
    r = W'(1);
    for (int i = 0; i < e; i++) r = fmul(r, a);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] lam_k(input int k);
    return lam_bus[k*W +: W];
  endfunction

  function automatic logic [W-1:0] om_k(input int k);
    return om_bus[k*W +: W];
  endfunction

  // Syndromes and true locator for an error pattern.
  logic [NS*W-1:0] pat_synd;
  logic [W-1:0]    pat_loc [0:T];

  task automatic make_pattern(input int nu, input bit unit_mag);
    int pos [0:T-1];
    logic [W-1:0] xl, yv, acc;
    pat_synd = '0;
    for (int k = 0; k <= T; k++) pat_loc[k] = (k == 0) ? W'(1) : '0;
    for (int i = 0; i < nu; i++) begin
      bit dup;
      do begin
        pos[i] = $urandom_range(0, 827);
        dup = 1'b0;
        for (int m = 0; m < i; m++) if (pos[m] == pos[i]) dup = 1'b1;
      end while (dup);
      xl = fpow(W'(2), pos[i]);
      yv = unit_mag ? W'(1) : W'($urandom_range(1, 1023));
      acc = yv;
      for (int j = 1; j <= NS; j++) begin
        acc = fmul(acc, xl);
        pat_synd[(j-1)*W +: W] = pat_synd[(j-1)*W +: W] ^ acc;
      end
      for (int k = T; k >= 1; k--) pat_loc[k] = pat_loc[k] ^ fmul(xl, pat_loc[k-1]);
    end
  endtask

  // Issue a start and wait for done; optionally pulse start again mid-run.
  task automatic run_solver(input logic [NS*W-1:0] bus, input bit poke,
                            input logic [NS*W-1:0] poke_bus, output int lat);
    @(negedge clk);
    synd_bus = bus;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = -1;
    for (int c = 1; c <= 200 && lat < 0; c++) begin
      if (poke && c == 40) begin
        synd_bus = poke_bus;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (done) lat = c;
    end
    start = 1'b0;
  endtask

  // Omega must be the low part of (1 + S(x)) * Lambda(x).
  task automatic check_omega(input logic [NS*W-1:0] bus, input string req);
    logic [W-1:0] e, sp;
    for (int k = 0; k <= T; k++) begin
      e = '0;
      for (int j = 0; j <= k; j++) begin
        sp = (j == 0) ? W'(1) : bus[(j-1)*W +: W];
        e = e ^ fmul(sp, lam_k(k-j));
      end
      chk(om_k(k) == e, req, 32'(om_k(k)), 32'(e));
    end
  endtask

  task automatic check_deg_obs(input string req);
    int d;
    d = 0;
    for (int k = 1; k <= T; k++) if (lam_k(k) != '0) d = k;
    chk(int'(deg) == d, req, 32'(deg), 32'(d));
  endtask

  task automatic check_correctable(input int nu, input logic [NS*W-1:0] bus);
    logic [W-1:0] l0;
    l0 = lam_k(0);
    chk(l0 != '0, "R3 lambda0 nonzero", 32'(l0), 32'h1);
    for (int k = 0; k <= T; k++)
      chk(lam_k(k) == fmul(pat_loc[k], l0), "R3 locator coeff",
          32'(lam_k(k)), 32'(fmul(pat_loc[k], l0)));
    check_omega(bus, "R4 evaluator");
    chk(int'(deg) == nu, "R5 degree", 32'(deg), 32'(nu));
  endtask

  task automatic after_done_low();
    @(negedge clk);
    chk(done == 1'b0, "R2 single-cycle done", 32'(done), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int nu;
    logic [NS*W-1:0] keep_bus;
    logic [(T+1)*W-1:0] keep_lam, keep_om;
    logic [2:0] keep_deg;
    void'($urandom(32'd20240607));
    start = 1'b0;
    synd_bus = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(done == 1'b0, "R1 done after reset", 32'(done), 32'h0);
    chk(lam_bus == '0, "R1 lambda after reset", lam_bus[31:0], 32'h0);
    chk(om_bus == '0, "R1 omega after reset", om_bus[31:0], 32'h0);
    chk(deg == '0, "R1 degree after reset", 32'(deg), 32'h0);

    // R6 all-zero syndromes
    run_solver('0, 1'b0, '0, lat);
    chk(lat == LAT, "R2 latency", 32'(lat), 32'(LAT));
    chk(lam_k(0) == W'(1), "R6 lambda0", 32'(lam_k(0)), 32'h1);
    chk(om_k(0) == W'(1), "R6 omega0", 32'(om_k(0)), 32'h1);
    for (int k = 1; k <= T; k++) begin
      chk(lam_k(k) == '0, "R6 lambda upper", 32'(lam_k(k)), 32'h0);
      chk(om_k(k) == '0, "R6 omega upper", 32'(om_k(k)), 32'h0);
    end
    chk(deg == '0, "R6 degree", 32'(deg), 32'h0);
    after_done_low();

    // single error of unit magnitude
    make_pattern(1, 1'b1);
    run_solver(pat_synd, 1'b0, '0, lat);
    chk(lat == LAT, "R2 latency", 32'(lat), 32'(LAT));
    check_correctable(1, pat_synd);
    after_done_low();

    // four errors: every locator slot occupied
    for (int r = 0; r < 3; r++) begin
      make_pattern(4, 1'b0);
      run_solver(pat_synd, 1'b0, '0, lat);
      chk(lat == LAT, "R2 latency", 32'(lat), 32'(LAT));
      check_correctable(4, pat_synd);
      after_done_low();
    end

    // R7 start while busy is ignored
    make_pattern(3, 1'b0);
    keep_bus = pat_synd;
    run_solver(keep_bus, 1'b1, {NS{10'h2A5}}, lat);
    chk(lat == LAT, "R7 latency unchanged by busy start", 32'(lat), 32'(LAT));
    check_correctable(3, keep_bus);
    after_done_low();

    // R8 outputs hold while synd_i changes without a start
    keep_lam = lam_bus;
    keep_om  = om_bus;
    keep_deg = deg;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      synd_bus = {$urandom(), $urandom(), 16'($urandom())};
    end
    @(negedge clk);
    chk(lam_bus == keep_lam, "R8 lambda held", lam_bus[31:0], keep_lam[31:0]);
    chk(om_bus == keep_om, "R8 omega held", om_bus[31:0], keep_om[31:0]);
    chk(deg == keep_deg, "R8 degree held", 32'(deg), 32'(keep_deg));

    // beyond the limit: random syndromes
    for (int r = 0; r < 4; r++) begin
      keep_bus = {$urandom(), $urandom(), 16'($urandom())};
      run_solver(keep_bus, 1'b0, '0, lat);
      chk(lat == LAT, "R2 latency", 32'(lat), 32'(LAT));
      check_omega(keep_bus, "R4 evaluator uncorrectable");
      check_deg_obs("R5 degree uncorrectable");
    end

    // constrained random correctable patterns
    for (int r = 0; r < 30; r++) begin
      nu = $urandom_range(0, T);
      make_pattern(nu, 1'b0);
      run_solver(pat_synd, 1'b0, '0, lat);
      chk(lat == LAT, "R2 latency", 32'(lat), 32'(LAT));
      check_correctable(nu, pat_synd);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule